// File: doc/BRIEF.md
# Interrupt Pending Flag Bank

This block holds one pending flag for each of 134 interrupt lines and exposes them on a simple 32-bit register bus. There are two register windows, each five words long. The set window starts at byte offset 0x200 and the clear window starts at 0x280, and words in both windows are 4 bytes apart. Software forces lines pending by writing ones into the set window. It removes pending flags by writing ones into the clear window. Reading a word in either window returns the current flags for that word. Bit j of word k stands for line 32k+j. The fifth word holds only lines 128 to 133, in bits 5:0.

Hardware sources raise flags through a per-line raise vector. A per-line acknowledge vector drops a flag once its interrupt has been taken. Every bus access carries a privilege qualifier. Unprivileged accesses are refused and get an error response. The full flag vector is also available as a direct output, for a downstream arbiter.

Top module: `irq_pend_bank`

## Requirements
- R1: After reset every pending flag is 0, and `rsp_valid` and `rsp_err` are 0.
- R2: A privileged write of 1 to bit j of set word k (offset 0x200+4k, address bits 1:0 ignored) makes line 32k+j pending from the next cycle, whether or not the line is enabled. A 0 bit leaves its flag as it was, and a 1 written to a flag that is already pending keeps it pending.
- R3: A 1 on `irq_raise[n]` makes line n pending in the cycle that follows.
- R4: A privileged write of 1 to bit j of clear word k (offset 0x280+4k) clears line 32k+j. A 0 bit has no effect, and no write to the set window can clear a flag.
- R5: A 1 on `irq_ack[n]` clears line n in the cycle that follows.
- R6: When a set (from hardware or software) reaches a line in the same cycle as a software clear or an acknowledge, the line ends up pending.
- R7: Every request gets `rsp_valid` one cycle later. A privileged read of either window returns the flags of the addressed word, with 1 meaning pending. Bits 31:6 of the fifth word always read 0, and writes to those bits change nothing.
- R8: An unprivileged access changes no flag, returns read data 0, and raises `rsp_err` only in its response cycle.
- R9: An access outside both windows changes no flag, returns read data 0, and gives no error.
- R10: `pend_o[n]` always shows the current pending state of line n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Access is privileged |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| irq_raise | input | 134 | Hardware set pulse per line |
| irq_ack | input | 134 | Taken acknowledge per line |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Error response for unprivileged access |
| pend_o | output | 134 | Current pending flags |

## Verification
A wrong flag inside the bank shows at `pend_o` in the cycle after the event that caused it. It also shows in the next read of that word, one cycle after the read request. The bench therefore checks `pend_o` right after every single event and reads words back through both windows. This catches set and clear swapped, a decode pointing at the wrong word, or bad ordering between set, clear and acknowledge within one response. Privilege and decode faults show up as `rsp_err` or read data that differ from what was expected in that same response cycle.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int WIX_W = 8;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;

  typedef struct packed {
    win_e             win;
    logic [WIX_W-1:0] word;
  } dec_t;
endpackage

// File: rtl/irq_pend_rst_sync.sv
module irq_pend_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/irq_pend_decode.sv
module irq_pend_decode
  import irq_pend_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 5,
  parameter int SET_BASE  = 'h200,
  parameter int CLR_BASE  = 'h280
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] SET_LO = ADDR_W'(SET_BASE);
  localparam logic [ADDR_W-1:0] SET_HI = ADDR_W'(SET_BASE + 4*NUM_WORDS);
  localparam logic [ADDR_W-1:0] CLR_LO = ADDR_W'(CLR_BASE);
  localparam logic [ADDR_W-1:0] CLR_HI = ADDR_W'(CLR_BASE + 4*NUM_WORDS);

  logic [ADDR_W-1:0] set_off;
  logic [ADDR_W-1:0] clr_off;

  always_comb begin
    set_off  = addr - SET_LO;
    clr_off  = addr - CLR_LO;
    dec.win  = WIN_NONE;
    dec.word = '0;
    if (addr >= SET_LO && addr < SET_HI) begin
      dec.win  = WIN_SET;
      dec.word = WIX_W'(set_off[ADDR_W-1:2]);
    end else if (addr >= CLR_LO && addr < CLR_HI) begin
      dec.win  = WIN_CLR;
      dec.word = WIX_W'(clr_off[ADDR_W-1:2]);
    end
  end
endmodule

// File: rtl/irq_pend_word.sv
module irq_pend_word #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_set,
  input  logic             sw_clr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] hw_set,
  input  logic [WIDTH-1:0] ack,
  output logic [WIDTH-1:0] pend
);
  logic [WIDTH-1:0] set_v;
  logic [WIDTH-1:0] clr_v;
  logic [WIDTH-1:0] pend_nxt;
  logic             pend_en;

  // set terms dominate clear terms
  always_comb begin
    set_v    = hw_set | (sw_set ? wdata : '0);
    clr_v    = ack | (sw_clr ? wdata : '0);
    pend_nxt = set_v | (pend & ~clr_v);
    pend_en  = (pend_nxt != pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (pend_en) begin
      pend <= pend_nxt;
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_pend_pkg::*;
#(
  parameter int NUM_IRQ  = 134,
  parameter int ADDR_W   = 12,
  parameter int SET_BASE = 'h200,
  parameter int CLR_BASE = 'h280
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_priv,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [NUM_IRQ-1:0] irq_raise,
  input  logic [NUM_IRQ-1:0] irq_ack,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic [NUM_IRQ-1:0] pend_o
);
  localparam int NUM_WORDS = (NUM_IRQ + 31) / 32;
  localparam int LAST_W    = NUM_IRQ - 32 * (NUM_WORDS - 1);

  logic        rst_sync_n;
  dec_t        dec;
  logic        acc_ok;
  logic        wr_ok;
  logic        rd_ok;
  logic [31:0] word_rd [NUM_WORDS];
  logic [31:0] rdata_nxt;
  logic        err_nxt;

  irq_pend_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_pend_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .SET_BASE  (SET_BASE),
    .CLR_BASE  (CLR_BASE)
  ) dec_i (
    .addr (req_addr),
    .dec  (dec)
  );

  always_comb begin
    acc_ok = req_valid & req_priv;
    wr_ok  = acc_ok & req_write;
    rd_ok  = acc_ok & ~req_write & (dec.win != WIN_NONE);
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int LO    = 32 * w;
    localparam int WIDTH = (w == NUM_WORDS - 1) ? LAST_W : 32;
    logic hit;

    assign hit = (dec.word == WIX_W'(w));

    irq_pend_word #(
      .WIDTH (WIDTH)
    ) word_i (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .sw_set (wr_ok & hit & (dec.win == WIN_SET)),
      .sw_clr (wr_ok & hit & (dec.win == WIN_CLR)),
      .wdata  (req_wdata[WIDTH-1:0]),
      .hw_set (irq_raise[LO +: WIDTH]),
      .ack    (irq_ack[LO +: WIDTH]),
      .pend   (pend_o[LO +: WIDTH])
    );

    assign word_rd[w] = 32'(pend_o[LO +: WIDTH]);
  end

  always_comb begin
    rdata_nxt = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rd_ok && dec.word == WIX_W'(w)) begin
        rdata_nxt = word_rd[w];
      end
    end
    err_nxt = req_valid & ~req_priv;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= err_nxt;
      if (req_valid) begin
        rsp_rdata <= rdata_nxt;
      end
    end
  end
endmodule

// File: rtl/irq_pend_bank_chk.sv
module irq_pend_bank_chk #(
  parameter int NUM_IRQ = 134
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_priv,
  input logic [NUM_IRQ-1:0] irq_raise,
  input logic [NUM_IRQ-1:0] irq_ack,
  input logic               rsp_valid,
  input logic [31:0]        rsp_rdata,
  input logic               rsp_err,
  input logic [NUM_IRQ-1:0] pend_o
);
  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raise != '0) |=> ((pend_o & $past(irq_raise)) == $past(irq_raise))); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && irq_raise == '0) |=> ((pend_o & $past(irq_ack)) == '0)); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && irq_raise == '0) |=> ((pend_o & ~$past(pend_o)) == '0)); // R2

  AST_UNPRIV_NOCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && irq_raise == '0 && irq_ack == '0) |=> $stable(pend_o)); // R8

  AST_UNPRIV_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv) |=> (rsp_err && rsp_rdata == '0)); // R8

  AST_PRIV_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && !req_priv)) |=> !rsp_err); // R8

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R7

  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R7
endmodule

bind irq_pend_bank irq_pend_bank_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_priv  (req_priv),
  .irq_raise (irq_raise),
  .irq_ack   (irq_ack),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .pend_o    (pend_o)
);

// File: tb/irq_pend_bank_tb_top.sv
module irq_pend_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 134;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic         req_priv = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic [N-1:0] irq_raise = '0;
  logic [N-1:0] irq_ack = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         rsp_err;
  logic [N-1:0] pend_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [N-1:0] exp_p = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_bank dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write), .req_priv (req_priv),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .irq_raise (irq_raise), .irq_ack (irq_ack),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .rsp_err (rsp_err),
    .pend_o (pend_o)
  );

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_pend(input string req);
    n_chk++;
    if (pend_o !== exp_p) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, pend_o, exp_p);
    end
  endtask

  task automatic access(input logic wr, input logic pv, input logic [11:0] a,
                        input logic [31:0] d, input logic [N-1:0] rs,
                        input logic [N-1:0] ak, output logic [31:0] rd,
                        output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_priv = pv; req_addr = a;
    req_wdata = d; irq_raise = rs; irq_ack = ak;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; irq_raise = '0; irq_ack = '0;
    rd = rsp_rdata;
    er = rsp_err;
    chk32("R7 rsp_valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic t_reset();
    chk_pend("R1 pend after reset");
    chk32("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk32("R1 rsp_err", {31'd0, rsp_err}, 32'd0);
  endtask

  task automatic t_sw_set();
    logic [31:0] rd; logic er;
    access(1, 1, 12'h200, 32'hA5, '0, '0, rd, er);
    access(1, 1, 12'h20C, 32'hFFFF_FFFF, '0, '0, rd, er);
    access(1, 1, 12'h210, 32'hFFFF_FFFF, '0, '0, rd, er);
    exp_p[7:0] = 8'hA5; exp_p[127:96] = '1; exp_p[133:128] = '1;
    chk_pend("R2 set writes");
    access(0, 1, 12'h210, '0, '0, '0, rd, er);
    chk32("R7 last word reserved bits", rd, 32'h3F);
    access(0, 1, 12'h20E, '0, '0, '0, rd, er);
    chk32("R2 low address bits ignored", rd, 32'hFFFF_FFFF);
    access(1, 1, 12'h200, 32'h0, '0, '0, rd, er);
    access(1, 1, 12'h200, 32'h1, '0, '0, rd, er);
    access(0, 1, 12'h200, '0, '0, '0, rd, er);
    chk32("R2 zero and repeat writes", rd, 32'hA5);
    chk32("R10 pend_o word0", {24'd0, pend_o[7:0]}, 32'hA5);
  endtask

  task automatic t_sw_clr();
    logic [31:0] rd; logic er;
    access(1, 1, 12'h280, 32'h05, '0, '0, rd, er);
    exp_p[7:0] = 8'hA0;
    access(0, 1, 12'h280, '0, '0, '0, rd, er);
    chk32("R4 read via clear window", rd, 32'hA0);
    access(1, 1, 12'h290, 32'h3, '0, '0, rd, er);
    access(1, 1, 12'h280, 32'h0, '0, '0, rd, er);
    exp_p[129:128] = 2'b00;
    chk_pend("R4 clear writes");
    access(0, 1, 12'h210, '0, '0, '0, rd, er);
    chk32("R4 word4 after clear", rd, 32'h3C);
  endtask

  task automatic t_hw();
    logic [31:0] rd; logic er;
    @(negedge clk);
    irq_raise[40] = 1'b1; irq_raise[131] = 1'b1;
    @(negedge clk);
    irq_raise = '0;
    exp_p[40] = 1'b1;
    chk_pend("R3 hw raise");
    access(0, 1, 12'h204, '0, '0, '0, rd, er);
    chk32("R3 read raised word", rd, 32'h100);
    @(negedge clk);
    irq_ack[40] = 1'b1;
    @(negedge clk);
    irq_ack = '0;
    exp_p[40] = 1'b0;
    chk_pend("R5 ack clears");
  endtask

  task automatic t_priority();
    logic [31:0] rd; logic er;
    logic [N-1:0] rs; logic [N-1:0] ak;
    access(1, 1, 12'h200, 32'h200, '0, '0, rd, er);
    exp_p[9] = 1'b1;
    rs = '0; rs[7] = 1'b1;
    ak = '0; ak[7] = 1'b1; ak[9] = 1'b1;
    access(1, 1, 12'h280, 32'h280, rs, ak, rd, er);
    exp_p[9] = 1'b0;
    chk_pend("R6 hw set beats clear and ack");
    ak = '0; ak[8] = 1'b1;
    access(1, 1, 12'h200, 32'h100, '0, ak, rd, er);
    exp_p[8] = 1'b1;
    chk_pend("R6 sw set beats ack");
  endtask

  task automatic t_unpriv();
    logic [31:0] rd; logic er;
    access(1, 0, 12'h204, 32'hFFFF, '0, '0, rd, er);
    chk32("R8 unpriv write err", {31'd0, er}, 32'd1);
    access(1, 0, 12'h280, 32'hFFFF_FFFF, '0, '0, rd, er);
    chk_pend("R8 unpriv writes ignored");
    access(0, 0, 12'h200, '0, '0, '0, rd, er);
    chk32("R8 unpriv read data", rd, 32'h0);
    chk32("R8 unpriv read err", {31'd0, er}, 32'd1);
    @(negedge clk);
    chk32("R8 err one cycle", {31'd0, rsp_err}, 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] rd; logic er;
    access(1, 1, 12'h300, 32'hFFFF_FFFF, '0, '0, rd, er);
    access(1, 1, 12'h214, 32'hFFFF_FFFF, '0, '0, rd, er);
    chk_pend("R9 unmapped writes ignored");
    access(0, 1, 12'h294, '0, '0, '0, rd, er);
    chk32("R9 unmapped read data", rd, 32'h0);
    chk32("R9 unmapped no err", {31'd0, er}, 32'd0);
    access(0, 1, 12'h1FC, '0, '0, '0, rd, er);
    chk32("R9 below window read", rd, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sw_set();
    t_sw_clr();
    t_hw();
    t_priority();
    t_unpriv();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule